// File: doc/BRIEF.md
# Cartridge Character Bank Mapper

This block sits on the cartridge side of an 8-bit console and turns the console's two address buses into ROM addresses. The CPU side sees a fixed program ROM of 16 KB or 32 KB. The PPU side sees an 8 KB window at PPU addresses $0000-$1FFF, and a small latch picks which of four character ROM banks fills that window. Any CPU write into the upper half of the CPU address space loads that latch. The ROM drives the data bus during the write at the same moment as the CPU, so the value that lands in the latch is the CPU data ANDed with the ROM byte at that address.

Two latch bits carry a security code. When the board is strapped for security, the character ROM is enabled only while the latched code equals the strapped code. Otherwise the ROM stays disabled and PPU pattern reads see an undriven bus. Other straps select the program ROM size and the nametable mirroring. The mirroring result drives the A10 line of the console's nametable RAM.

Top module: `chr_bank_mapper`

## Requirements
- R1: The latch loads at a rising clock edge only when `cpu_wr`=1, `rom_sel_n`=0 and `cpu_addr[15]`=1 are all true. The new value shows on the outputs from the next cycle. A write with `rom_sel_n`=1 leaves the latch unchanged.
- R2: The value loaded is `cpu_data & prg_rom_data`. Writing $FF over a ROM byte of $02 selects bank 2.
- R3: `chr_addr` = {bank, `ppu_addr[12:0]`}, 15 bits wide. The bank is the loaded data bits 1:0 and sits in `chr_addr[14:13]`.
- R4: Loaded data bits 7:6 and 3:2 affect no output.
- R5: With `strap_prg32`=1, `prg_addr` = `cpu_addr[14:0]`. With `strap_prg32`=0, `prg_addr[14]`=0 and `prg_addr[13:0]` = `cpu_addr[13:0]`, so the one 16 KB bank appears in both halves.
- R6: `ciram_a10` follows `ppu_addr[10]` when `strap_mirror_h`=0 (vertical mirroring) and follows `ppu_addr[11]` when `strap_mirror_h`=1 (horizontal mirroring).
- R7: `chr_ce` is 0 whenever `ppu_addr[13]`=1.
- R8: With `strap_sec_en`=1, `chr_ce` is 0 for every bank value while the loaded data bits 5:4 differ from `strap_sec_code`. It is 1 for pattern addresses once they match.
- R9: With `strap_sec_en`=0, the loaded bits 5:4 have no effect. `chr_ce` = NOT `ppu_addr[13]`.
- R10: Reset (`rst_n`=0) clears the latch to zero, which gives bank 0 and security code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the latch samples on the rising edge |
| rst_n | input | 1 | Active-low reset, clears the latch |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | Data the CPU drives during a write |
| cpu_wr | input | 1 | CPU write strobe, active high |
| rom_sel_n | input | 1 | Program ROM select, active low |
| prg_rom_data | input | 8 | Byte the program ROM drives at the current address |
| strap_prg32 | input | 1 | 1: 32 KB program ROM, 0: 16 KB |
| strap_mirror_h | input | 1 | 1: horizontal mirroring, 0: vertical |
| strap_sec_en | input | 1 | 1: security check active |
| strap_sec_code | input | 2 | Expected security code |
| ppu_addr | input | 14 | PPU address bus |
| prg_addr | output | 15 | Program ROM address |
| chr_addr | output | 15 | Character ROM address |
| chr_ce | output | 1 | Character ROM enable; 0 means the PPU sees open bus |
| ciram_a10 | output | 1 | Nametable RAM A10 |

## Verification
The bench builds the mapper with its default parameters: a 2-bit bank field, a 2-bit security field at data bit 4, the security comparator present, and 15-bit program and character addresses. With these values all four banks and every mismatching code can be reached, so the bench can sweep each bank under a wrong code. It also walks both program sizes and both mirroring modes against a behavioural model that is compared every cycle.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
   typedef enum logic {
      MIR_VERT  = 1'b0,
      MIR_HORIZ = 1'b1
   } mirror_e;

   localparam int DEF_SEC_LSB = 4;
endpackage

// File: rtl/cbm_latch.sv
module cbm_latch #(
   parameter int DW      = 8,
   parameter int BANK_W  = 2,
   parameter int SEC_W   = 2,
   parameter int SEC_LSB = cbm_pkg::DEF_SEC_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DW-1:0]     wdata,
   input  logic [DW-1:0]     rom_data,
   output logic [BANK_W-1:0] bank_q,
   output logic [SEC_W-1:0]  sec_q
);
   logic [DW-1:0] bus_val;
   logic          unused_bits;

   initial begin
      assert (SEC_LSB >= BANK_W && SEC_LSB + SEC_W <= DW)
         else $error("cbm_latch: security field placement invalid");
   end

   // The ROM and the CPU drive the bus together; a low from either wins.
   assign bus_val     = wdata & rom_data;
   assign unused_bits = ^bus_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= '0;
         sec_q  <= '0;
      end else if (load) begin
         bank_q <= bus_val[BANK_W-1:0];
         sec_q  <= bus_val[SEC_LSB +: SEC_W];
      end
   end
endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map #(
   parameter int PRG_AW = 15
) (
   input  logic [PRG_AW-1:0] cpu_addr,
   input  logic              prg32,
   output logic [PRG_AW-1:0] prg_addr
);
   localparam int TOP = PRG_AW - 1;

   initial begin
      assert (PRG_AW >= 2) else $error("cbm_prg_map: PRG_AW too small");
   end

   always_comb begin
      prg_addr      = cpu_addr;
      prg_addr[TOP] = cpu_addr[TOP] & prg32;
   end
endmodule

// File: rtl/cbm_chr_map.sv
module cbm_chr_map #(
   parameter int BANK_W      = 2,
   parameter int SEC_W       = 2,
   parameter int PPU_AW      = 14,
   parameter bit SEC_PRESENT = 1'b1,
   localparam int WIN_W      = PPU_AW - 1,
   localparam int CHR_AW     = BANK_W + WIN_W
) (
   input  logic [BANK_W-1:0] bank,
   input  logic [SEC_W-1:0]  sec,
   input  logic              sec_en,
   input  logic [SEC_W-1:0]  sec_code,
   input  logic [PPU_AW-1:0] ppu_addr,
   output logic [CHR_AW-1:0] chr_addr,
   output logic              chr_ce
);
   logic pattern_sel;
   logic sec_ok;

   initial begin
      assert (PPU_AW >= 12 && BANK_W >= 1 && SEC_W >= 1)
         else $error("cbm_chr_map: width parameters invalid");
   end

   assign pattern_sel = ~ppu_addr[PPU_AW-1];
   assign chr_addr    = {bank, ppu_addr[WIN_W-1:0]};

   generate
      if (SEC_PRESENT) begin : g_sec
         assign sec_ok = ~sec_en | (sec == sec_code);
      end else begin : g_nosec
         logic unused_sec;
         assign unused_sec = ^{sec, sec_en, sec_code};
         assign sec_ok     = 1'b1;
      end
   endgenerate

   assign chr_ce = pattern_sel & sec_ok;
endmodule

// File: rtl/cbm_mirror.sv
module cbm_mirror (
   input  logic            ppu_a10,
   input  logic            ppu_a11,
   input  cbm_pkg::mirror_e mode,
   output logic            ciram_a10
);
   always_comb begin
      unique case (mode)
         cbm_pkg::MIR_HORIZ: ciram_a10 = ppu_a11;
         default:            ciram_a10 = ppu_a10;
      endcase
   end
endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper #(
   parameter int CPU_AW      = 16,
   parameter int DW          = 8,
   parameter int BANK_W      = 2,
   parameter int SEC_W       = 2,
   parameter int SEC_LSB     = cbm_pkg::DEF_SEC_LSB,
   parameter int PPU_AW      = 14,
   parameter bit SEC_PRESENT = 1'b1,
   localparam int PRG_AW     = CPU_AW - 1,
   localparam int CHR_AW     = BANK_W + PPU_AW - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [DW-1:0]     cpu_data,
   input  logic              cpu_wr,
   input  logic              rom_sel_n,
   input  logic [DW-1:0]     prg_rom_data,
   input  logic              strap_prg32,
   input  logic              strap_mirror_h,
   input  logic              strap_sec_en,
   input  logic [SEC_W-1:0]  strap_sec_code,
   input  logic [PPU_AW-1:0] ppu_addr,
   output logic [PRG_AW-1:0] prg_addr,
   output logic [CHR_AW-1:0] chr_addr,
   output logic              chr_ce,
   output logic              ciram_a10
);
   logic              load;
   logic [BANK_W-1:0] bank_q;
   logic [SEC_W-1:0]  sec_q;
   cbm_pkg::mirror_e  mir_mode;

   initial begin
      assert (CPU_AW >= 2 && DW >= BANK_W + SEC_W)
         else $error("chr_bank_mapper: parameter set invalid");
   end

   assign load     = cpu_wr & ~rom_sel_n & cpu_addr[CPU_AW-1];
   assign mir_mode = strap_mirror_h ? cbm_pkg::MIR_HORIZ : cbm_pkg::MIR_VERT;

   cbm_latch #(.DW(DW), .BANK_W(BANK_W), .SEC_W(SEC_W), .SEC_LSB(SEC_LSB)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .wdata    (cpu_data),
      .rom_data (prg_rom_data),
      .bank_q   (bank_q),
      .sec_q    (sec_q)
   );

   cbm_prg_map #(.PRG_AW(PRG_AW)) u_prg (
      .cpu_addr (cpu_addr[PRG_AW-1:0]),
      .prg32    (strap_prg32),
      .prg_addr (prg_addr)
   );

   cbm_chr_map #(.BANK_W(BANK_W), .SEC_W(SEC_W), .PPU_AW(PPU_AW),
                 .SEC_PRESENT(SEC_PRESENT)) u_chr (
      .bank     (bank_q),
      .sec      (sec_q),
      .sec_en   (strap_sec_en),
      .sec_code (strap_sec_code),
      .ppu_addr (ppu_addr),
      .chr_addr (chr_addr),
      .chr_ce   (chr_ce)
   );

   cbm_mirror u_mir (
      .ppu_a10   (ppu_addr[10]),
      .ppu_a11   (ppu_addr[11]),
      .mode      (mir_mode),
      .ciram_a10 (ciram_a10)
   );
endmodule

// File: rtl/cbm_chk.sv
module cbm_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] cpu_addr,
   input logic [7:0]  cpu_data,
   input logic        cpu_wr,
   input logic        rom_sel_n,
   input logic [7:0]  prg_rom_data,
   input logic        strap_prg32,
   input logic        strap_mirror_h,
   input logic        strap_sec_en,
   input logic [1:0]  strap_sec_code,
   input logic [13:0] ppu_addr,
   input logic [14:0] prg_addr,
   input logic [14:0] chr_addr,
   input logic        chr_ce,
   input logic        ciram_a10
);
   logic [7:0] conflict_val;
   logic       wr_hit;
   assign conflict_val = cpu_data & prg_rom_data;
   assign wr_hit       = cpu_wr & ~rom_sel_n & cpu_addr[15];

   AST_BANK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> chr_addr[14:13] == $past(conflict_val[1:0])); // R2

   AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(chr_addr[14:13])); // R1

   AST_WINDOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      chr_addr[12:0] == ppu_addr[12:0]); // R3

   AST_PRG_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      !strap_prg32 |-> (prg_addr[14] == 1'b0 && prg_addr[13:0] == cpu_addr[13:0])); // R5

   AST_MIRROR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      ciram_a10 == (strap_mirror_h ? ppu_addr[11] : ppu_addr[10])); // R6

   AST_CE_PATTERN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      ppu_addr[13] |-> !chr_ce); // R7

   AST_NOSEC_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!strap_sec_en && !ppu_addr[13]) |-> chr_ce); // R9
endmodule

bind chr_bank_mapper cbm_chk u_chk (.*);

// File: tb/chr_bank_mapper_tb.sv
module chr_bank_mapper_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h8000;
   logic [7:0]  cpu_data = 8'h00;
   logic        cpu_wr = 1'b0;
   logic        rom_sel_n = 1'b1;
   logic [7:0]  prg_rom_data = 8'hFF;
   logic        strap_prg32 = 1'b1;
   logic        strap_mirror_h = 1'b0;
   logic        strap_sec_en = 1'b0;
   logic [1:0]  strap_sec_code = 2'b00;
   logic [13:0] ppu_addr = 14'h0000;
   logic [14:0] prg_addr;
   logic [14:0] chr_addr;
   logic        chr_ce;
   logic        ciram_a10;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   chr_bank_mapper u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_wr(cpu_wr), .rom_sel_n(rom_sel_n), .prg_rom_data(prg_rom_data),
      .strap_prg32(strap_prg32), .strap_mirror_h(strap_mirror_h),
      .strap_sec_en(strap_sec_en), .strap_sec_code(strap_sec_code),
      .ppu_addr(ppu_addr), .prg_addr(prg_addr), .chr_addr(chr_addr),
      .chr_ce(chr_ce), .ciram_a10(ciram_a10)
   );

   // behavioural reference state
   int m_bank = 0;
   int m_sec = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_bank <= 0;
         m_sec  <= 0;
      end else if (cpu_wr && !rom_sel_n && cpu_addr[15]) begin
         m_bank <= int'((cpu_data & prg_rom_data) % 4);
         m_sec  <= int'(((cpu_data & prg_rom_data) / 16) % 4);
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int e_prg;
         int e_ce;
         e_prg = strap_prg32 ? int'(cpu_addr % 32768) : int'(cpu_addr % 16384);
         e_ce  = (ppu_addr >= 14'h2000) ? 0 :
                 ((!strap_sec_en || m_sec == int'(strap_sec_code)) ? 1 : 0);
         chk("R5 prg_addr", int'(prg_addr), e_prg);
         chk("R3 chr_addr", int'(chr_addr), m_bank * 8192 + int'(ppu_addr % 8192));
         chk("R8 chr_ce", int'(chr_ce), e_ce);
         chk("R6 ciram_a10", int'(ciram_a10),
             strap_mirror_h ? int'(ppu_addr[11]) : int'(ppu_addr[10]));
      end
   end

   task automatic write_reg(input logic [7:0] d, input logic [7:0] rom, input logic sel_n);
      @(posedge clk); #2;
      cpu_addr = 16'hC123; cpu_data = d; prg_rom_data = rom;
      rom_sel_n = sel_n; cpu_wr = 1'b1;
      @(posedge clk); #2;
      cpu_wr = 1'b0; rom_sel_n = 1'b1;
      @(negedge clk); #1;
   endtask

   task automatic set_ppu(input logic [13:0] a);
      @(posedge clk); #2;
      ppu_addr = a;
      @(negedge clk); #1;
   endtask

   initial begin
      #(8 * 200000);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      ppu_addr = 14'h0123;
      @(negedge clk); #1;
      // R10: reset leaves bank 0
      chk("R10 reset bank", int'(chr_addr), 16'h0123);

      // R2: $FF written over ROM byte $02 gives bank 2
      write_reg(8'hFF, 8'h02, 1'b0);
      chk("R2 bus conflict bank", int'(chr_addr[14:13]), 2);

      // R3: window pass-through
      set_ppu(14'h1FFF);
      chk("R3 window top", int'(chr_addr), 15'h5FFF);
      set_ppu(14'h0A55);
      chk("R3 window mid", int'(chr_addr), 15'h4A55);

      // R4: ignored bits; $CD -> bank 1, code 00
      write_reg(8'hCD, 8'hFF, 1'b0);
      chk("R4 ignored bits", int'(chr_addr[14:13]), 1);
      write_reg(8'hCC, 8'hFF, 1'b0);
      chk("R4 ignored bits zero bank", int'(chr_addr[14:13]), 0);

      // R1: no load without ROM select
      write_reg(8'h03, 8'hFF, 1'b1);
      chk("R1 no select no load", int'(chr_addr[14:13]), 0);
      write_reg(8'h03, 8'hFF, 1'b0);
      chk("R1 selected load", int'(chr_addr[14:13]), 3);

      // R5: program size
      @(posedge clk); #2; cpu_addr = 16'hC456; strap_prg32 = 1'b0;
      @(negedge clk); #1;
      chk("R5 16K fold", int'(prg_addr), 15'h0456);
      @(posedge clk); #2; strap_prg32 = 1'b1;
      @(negedge clk); #1;
      chk("R5 32K", int'(prg_addr), 15'h4456);

      // R6: mirroring
      set_ppu(14'h2800);
      chk("R6 vertical", int'(ciram_a10), 0);
      @(posedge clk); #2; strap_mirror_h = 1'b1;
      @(negedge clk); #1;
      chk("R6 horizontal", int'(ciram_a10), 1);

      // R7: non-pattern address never enables
      chk("R7 ce outside window", int'(chr_ce), 0);
      set_ppu(14'h0040);
      chk("R7 ce inside window", int'(chr_ce), 1);

      // R8: security mismatch blocks every bank
      @(posedge clk); #2; strap_sec_en = 1'b1; strap_sec_code = 2'b10;
      for (int b = 0; b < 4; b++) begin
         write_reg(8'(b), 8'hFF, 1'b0);
         chk("R8 mismatch blocks", int'(chr_ce), 0);
      end
      write_reg(8'h13, 8'hFF, 1'b0);
      chk("R8 wrong code blocks", int'(chr_ce), 0);
      write_reg(8'h23, 8'hFF, 1'b0);
      chk("R8 match restores", int'(chr_ce), 1);
      chk("R8 match bank", int'(chr_addr[14:13]), 3);
      // conflict can clear the code
      write_reg(8'h23, 8'h0F, 1'b0);
      chk("R8 conflict clears code", int'(chr_ce), 0);

      // R9: security off ignores code
      @(posedge clk); #2; strap_sec_en = 1'b0;
      write_reg(8'h31, 8'hFF, 1'b0);
      chk("R9 code ignored", int'(chr_ce), 1);
      chk("R9 bank still set", int'(chr_addr[14:13]), 1);

      // pattern sweep
      for (int i = 0; i < 40; i++) begin
         write_reg(8'(i * 37), 8'(8'hF0 | i), 1'b0);
         set_ppu(14'(i * 411));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule